// File: doc/BRIEF.md
# Victim Line Buffer

This block is a small, fully associative store that sits beside a direct-mapped L1 cache and keeps the lines L1 has most recently thrown out. Every line that leaves L1 is offered on the insert port, together with its dirty flag. Every L1 access also presents its line address on the lookup port in the same cycle. The hit flag, the line data and the dirty flag come back combinationally, so a victim hit costs no more time than an L1 hit.

On a victim hit the matching line goes back into L1. If L1 displaces a line in that same cycle, the displaced line is written into the entry the hit line vacates. A swap therefore never needs room and never produces an L2 writeback.

When a plain insert finds every entry occupied, the least recently used entry gives up its place. A dirty displaced line is handed to L2 over a valid/ready port. A clean one is dropped. While a writeback waits for L2 to accept it, plain inserts are held off, so no line is lost.

Top module: `victim_buf`

## Requirements
- R1: After reset the buffer is empty: no lookup hits, `wb_valid` is 0 and `ins_ready` is 1.
- R2: A lookup whose address matches a valid entry raises `lk_hit` in the same cycle, with that entry's data on `lk_data` and its dirty flag on `lk_dirty`.
- R3: A lookup of an address held by no valid entry leaves `lk_hit` at 0.
- R4: A clocked lookup hit with no insert in the same cycle removes the hit line from the buffer, so a later lookup of that address misses.
- R5: A clocked lookup hit together with an insert (a swap) stores the inserted line, removes the hit line and starts no writeback. `ins_ready` is 1 during a swap even while a writeback is pending.
- R6: A plain insert into a full buffer displaces the least recently used entry. Recency is the order in which entries were last written. If the displaced line is dirty, it appears on `wb_addr` and `wb_data` with `wb_valid` at 1 from the next cycle.
- R7: A clean line displaced by a plain insert is dropped without raising `wb_valid`.
- R8: While `wb_valid` is 1 and `wb_ready` is 0, the writeback address and data hold steady and `ins_ready` is 0 for an insert that is not a swap. A cycle with `wb_valid` and `wb_ready` both at 1 ends the writeback.
- R9: The line written by a swap becomes the most recently used entry.
- R10: A plain insert uses a free entry whenever one exists, so no held line is displaced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request, issued alongside every L1 access |
| lk_addr | input | AW | Line address being looked up |
| lk_hit | output | 1 | Lookup matched a held line |
| lk_data | output | DW | Data of the matched line |
| lk_dirty | output | 1 | Dirty flag of the matched line |
| ins_valid | input | 1 | L1 offers an evicted line |
| ins_addr | input | AW | Line address of the evicted line |
| ins_data | input | DW | Data of the evicted line |
| ins_dirty | input | 1 | Dirty flag of the evicted line |
| ins_ready | output | 1 | Insert is accepted this cycle |
| wb_valid | output | 1 | A dirty displaced line is waiting for L2 |
| wb_addr | output | AW | Line address of the writeback |
| wb_data | output | DW | Data of the writeback |
| wb_ready | input | 1 | L2 accepts the writeback |

## Verification
The buffer is filled with alternating dirty and clean lines, and each line is then probed without clocking. This shows whether the tag match and the data mux pick the right entry. A fifth insert is made with a dirty oldest entry and again with a clean one, which separates writeback from drop. A swap is made on the oldest entry, followed by another plain insert. That insert shows whether the swap refreshed the entry's recency: a wrong order would evict the swapped-in line. A drain without insert followed by an insert shows whether free entries are used before a full eviction. A swap made while a writeback is stalled shows that swaps bypass the insert stall and leave the pending writeback untouched.

// File: rtl/vbuf_pkg.sv
package vbuf_pkg;

  typedef enum logic [1:0] {
    FILL_NONE  = 2'd0,
    FILL_FREE  = 2'd1,
    FILL_SWAP  = 2'd2,
    FILL_EVICT = 2'd3
  } fill_kind_e;

  // Recency rank after a write: the written entry drops to rank 0, and
  // entries younger than its previous rank age by one.
  function automatic int unsigned rank_after_write(input int unsigned cur,
                                                   input int unsigned written_rank,
                                                   input bit          is_written);
    if (is_written)              return 0;
    else if (cur < written_rank) return cur + 1;
    else                         return cur;
  endfunction

endpackage

// File: rtl/vbuf_match.sv
module vbuf_match #(
  parameter int unsigned N  = 4,
  parameter int unsigned AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  valid_q,
  input  logic [AW-1:0] tag_q [N],
  input  logic [AW-1:0] addr,
  output logic [N-1:0]  match
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = valid_q[g] && (tag_q[g] == addr);
  end

  // R2: exclusive contents, so at most one entry may match
  p_single_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
endmodule

// File: rtl/vbuf_lru.sv
module vbuf_lru #(
  parameter int unsigned N  = 4,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [N-1:0]  valid_q,
  output logic          full,
  output logic [IW-1:0] victim_idx
);
  import vbuf_pkg::*;

  logic [IW-1:0] rank_q [N];
  logic [N-1:0]  oldest;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) rank_q[i] <= IW'(i);
    end else if (wr_en) begin
      for (int i = 0; i < N; i++)
        rank_q[i] <= IW'(rank_after_write(int'(rank_q[i]), int'(rank_q[wr_idx]),
                                          wr_idx == IW'(i)));
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_old
    assign oldest[g] = (rank_q[g] == IW'(N-1));
  end

  assign full = &valid_q;

  always_comb begin
    victim_idx = '0;
    if (full) begin
      for (int i = N-1; i >= 0; i--) if (oldest[i]) victim_idx = IW'(i);
    end else begin
      for (int i = N-1; i >= 0; i--) if (!valid_q[i]) victim_idx = IW'(i);
    end
  end

  // R6: ranks stay a permutation, so exactly one entry is the oldest
  p_one_oldest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(oldest));
endmodule

// File: rtl/vbuf_wb.sv
module vbuf_wb #(
  parameter int unsigned AW = 24,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  output logic          wb_valid,
  output logic [AW-1:0] wb_addr,
  output logic [DW-1:0] wb_data,
  input  logic          wb_ready
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
      wb_addr  <= '0;
      wb_data  <= '0;
    end else if (load) begin
      wb_valid <= 1'b1;
      wb_addr  <= ld_addr;
      wb_data  <= ld_data;
    end else if (wb_ready) begin
      wb_valid <= 1'b0;
    end
  end

  // R8: a stalled writeback keeps its payload
  p_wb_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr) && $stable(wb_data)));
endmodule

// File: rtl/victim_buf.sv
module victim_buf #(
  parameter int unsigned N  = 4,
  parameter int unsigned AW = 24,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lk_valid,
  input  logic [AW-1:0] lk_addr,
  output logic          lk_hit,
  output logic [DW-1:0] lk_data,
  output logic          lk_dirty,
  input  logic          ins_valid,
  input  logic [AW-1:0] ins_addr,
  input  logic [DW-1:0] ins_data,
  input  logic          ins_dirty,
  output logic          ins_ready,
  output logic          wb_valid,
  output logic [AW-1:0] wb_addr,
  output logic [DW-1:0] wb_data,
  input  logic          wb_ready
);
  import vbuf_pkg::*;
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]  valid_q, dirty_q, match;
  logic [AW-1:0] tag_q  [N];
  logic [DW-1:0] data_q [N];
  logic [IW-1:0] hit_idx, victim_idx, fill_idx;
  logic          full, ins_fire, swap_evt, drain_evt, evict_evt, wb_load;
  fill_kind_e    fill_kind;

  vbuf_match #(.N(N), .AW(AW)) match_i (
    .clk(clk), .rst_n(rst_n), .valid_q(valid_q), .tag_q(tag_q),
    .addr(lk_addr), .match(match));

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < N; i++) if (match[i]) hit_idx = IW'(i);
  end

  assign lk_hit   = lk_valid && (|match);
  assign lk_data  = data_q[hit_idx];
  assign lk_dirty = dirty_q[hit_idx];

  // Named events for the checks below
  assign ins_ready = lk_hit || !wb_valid;
  assign ins_fire  = ins_valid && ins_ready;
  assign swap_evt  = ins_fire && lk_hit;
  assign drain_evt = lk_hit && !ins_valid;
  assign evict_evt = ins_fire && !lk_hit && full;
  assign wb_load   = evict_evt && dirty_q[victim_idx];
  assign fill_idx  = lk_hit ? hit_idx : victim_idx;

  always_comb begin
    if (!ins_fire)      fill_kind = FILL_NONE;
    else if (lk_hit)    fill_kind = FILL_SWAP;
    else if (full)      fill_kind = FILL_EVICT;
    else                fill_kind = FILL_FREE;
  end

  vbuf_lru #(.N(N)) lru_i (
    .clk(clk), .rst_n(rst_n), .wr_en(ins_fire), .wr_idx(fill_idx),
    .valid_q(valid_q), .full(full), .victim_idx(victim_idx));

  vbuf_wb #(.AW(AW), .DW(DW)) wb_i (
    .clk(clk), .rst_n(rst_n), .load(wb_load),
    .ld_addr(tag_q[victim_idx]), .ld_data(data_q[victim_idx]),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data),
    .wb_ready(wb_ready));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
      for (int i = 0; i < N; i++) begin
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end
    end else if (fill_kind != FILL_NONE) begin
      valid_q[fill_idx] <= 1'b1;
      dirty_q[fill_idx] <= ins_dirty;
      tag_q[fill_idx]   <= ins_addr;
      data_q[fill_idx]  <= ins_data;
    end else if (drain_evt) begin
      valid_q[hit_idx] <= 1'b0;
    end
  end

  // R5: a swap never starts a writeback
  p_swap_no_wb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_evt && !wb_valid) |=> !wb_valid);
  // R10: a displacement only happens once every entry is occupied
  p_evict_when_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_kind == FILL_EVICT) |-> (valid_q == {N{1'b1}}));
endmodule

// File: tb/victim_buf_tb.sv
module victim_buf_tb_top;
  localparam int AW = 24;
  localparam int DW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 0, ins_valid = 0, ins_dirty = 0, wb_ready = 0;
  logic [AW-1:0] lk_addr = '0, ins_addr = '0;
  logic [DW-1:0] ins_data = '0;
  logic lk_hit, lk_dirty, ins_ready, wb_valid;
  logic [DW-1:0] lk_data, wb_data;
  logic [AW-1:0] wb_addr;
  int vecs = 0, miss = 0;

  always #4 clk = ~clk;

  victim_buf #(.N(4), .AW(AW), .DW(DW)) dut_i (.*);

  function automatic logic [AW-1:0] la(input int i);
    return AW'(24'h10_0000 + i * 24'h40);
  endfunction
  function automatic logic [DW-1:0] ld(input logic [AW-1:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic probe(input logic [AW-1:0] a, input string req,
                       input logic exp_hit, input logic exp_dirty);
    @(negedge clk); lk_valid = 1; lk_addr = a; #1;
    chk(req, {63'd0, lk_hit}, {63'd0, exp_hit});
    if (exp_hit) begin
      chk(req, {32'd0, lk_data}, {32'd0, ld(a)});
      chk(req, {63'd0, lk_dirty}, {63'd0, exp_dirty});
    end
    #1 lk_valid = 0;
  endtask

  task automatic ins(input logic [AW-1:0] a, input logic d);
    @(negedge clk); ins_valid = 1; ins_addr = a; ins_data = ld(a); ins_dirty = d;
    @(posedge clk); #1 ins_valid = 0;
  endtask

  task automatic t_reset;
    #1;
    chk("R1 wb_valid", {63'd0, wb_valid}, 64'd0);
    chk("R1 ins_ready", {63'd0, ins_ready}, 64'd1);
    probe(la(0), "R1 empty", 0, 0);
  endtask

  task automatic t_fill;
    ins(la(0), 1); ins(la(1), 0); ins(la(2), 1); ins(la(3), 0);
    probe(la(0), "R2 e0", 1, 1); probe(la(1), "R2 e1", 1, 0);
    probe(la(2), "R2 e2", 1, 1); probe(la(3), "R2 e3", 1, 0);
    probe(la(9), "R3 absent", 0, 0);
    chk("R10 no wb while filling", {63'd0, wb_valid}, 64'd0);
  endtask

  task automatic t_evict_dirty;
    ins(la(4), 0);                       // oldest la(0) dirty
    chk("R6 wb_valid", {63'd0, wb_valid}, 64'd1);
    chk("R6 wb_addr", {40'd0, wb_addr}, {40'd0, la(0)});
    chk("R6 wb_data", {32'd0, wb_data}, {32'd0, ld(la(0))});
    probe(la(0), "R6 gone", 0, 0);
    probe(la(4), "R6 new", 1, 0);
    @(negedge clk); ins_valid = 1; ins_addr = la(5); #1;
    chk("R8 stall", {63'd0, ins_ready}, 64'd0);
    @(posedge clk); #1 ins_valid = 0;
    chk("R8 still valid", {63'd0, wb_valid}, 64'd1);
    chk("R8 addr held", {40'd0, wb_addr}, {40'd0, la(0)});
    probe(la(5), "R8 stalled line not taken", 0, 0);
    @(negedge clk); wb_ready = 1; @(posedge clk); #1 wb_ready = 0;
    chk("R8 done", {63'd0, wb_valid}, 64'd0);
    chk("R8 ready again", {63'd0, ins_ready}, 64'd1);
  endtask

  task automatic t_evict_clean;
    ins(la(5), 1);                       // oldest la(1) clean
    chk("R7 no wb", {63'd0, wb_valid}, 64'd0);
    probe(la(1), "R7 dropped", 0, 0);
    probe(la(5), "R7 new", 1, 1);
  endtask

  task automatic t_swap;
    @(negedge clk); lk_valid = 1; lk_addr = la(2);
    ins_valid = 1; ins_addr = la(20); ins_data = ld(la(20)); ins_dirty = 1; #1;
    chk("R5 hit", {63'd0, lk_hit}, 64'd1);
    chk("R5 data out", {32'd0, lk_data}, {32'd0, ld(la(2))});
    chk("R5 ready", {63'd0, ins_ready}, 64'd1);
    @(posedge clk); #1 lk_valid = 0; ins_valid = 0;
    chk("R5 no wb", {63'd0, wb_valid}, 64'd0);
    probe(la(2), "R5 old removed", 0, 0);
    probe(la(20), "R5 new stored", 1, 1);
    ins(la(6), 0);                       // oldest now la(3) clean
    probe(la(3), "R9 oldest dropped", 0, 0);
    probe(la(20), "R9 swapped line kept", 1, 1);
    chk("R9 no wb", {63'd0, wb_valid}, 64'd0);
  endtask

  task automatic t_drain;
    @(negedge clk); lk_valid = 1; lk_addr = la(4);
    @(posedge clk); #1 lk_valid = 0;
    probe(la(4), "R4 removed", 0, 0);
    ins(la(7), 1);
    chk("R10 no wb", {63'd0, wb_valid}, 64'd0);
    probe(la(5), "R10 kept a", 1, 1);
    probe(la(20), "R10 kept b", 1, 1);
    probe(la(6), "R10 kept c", 1, 0);
    probe(la(7), "R10 new", 1, 1);
  endtask

  task automatic t_swap_during_wb;
    ins(la(8), 0);                       // oldest la(5) dirty
    chk("R6 wb la5", {40'd0, wb_addr}, {40'd0, la(5)});
    @(negedge clk); lk_valid = 1; lk_addr = la(20);
    ins_valid = 1; ins_addr = la(21); ins_data = ld(la(21)); ins_dirty = 0; #1;
    chk("R5 ready while wb pending", {63'd0, ins_ready}, 64'd1);
    @(posedge clk); #1 lk_valid = 0; ins_valid = 0;
    chk("R8 wb kept", {40'd0, wb_addr}, {40'd0, la(5)});
    chk("R8 wb valid kept", {63'd0, wb_valid}, 64'd1);
    probe(la(21), "R5 swap in", 1, 0);
    probe(la(20), "R5 swap out", 0, 0);
    @(negedge clk); wb_ready = 1; @(posedge clk); #1 wb_ready = 0;
    chk("R8 cleared", {63'd0, wb_valid}, 64'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_fill();
    t_evict_dirty();
    t_evict_clean();
    t_swap();
    t_drain();
    t_swap_during_wb();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    #(8 * 200000);
    miss++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule